// File: doc/BRIEF.md
# Tagged Multi-Line Receive Silo

This block collects received characters from sixteen serial lines into one shared first-in first-out store. Each line's receiver hands over a character with a one-cycle valid strobe, along with the sampled parity bit and stop-bit levels. The block checks the character against that line's programmed format (length, parity, stop bits), tags it with the line number and error flags, and queues it as a single 16-bit word. Software drains the store by reading the receive word repeatedly until bit 15 comes back clear.

Arrivals are held one per line and moved into the store one per cycle, lowest line number first. When the store is full the character is lost and the next stored entry carries an overrun flag. A programmable alarm level raises a sticky receive flag, which drives the interrupt output when enabled. A master-clear bit returns the whole block to its reset state.

Top module: `rx_silo`

## Requirements
- R1: A read of the receive word (address 1, with rd_i) on a non-empty store returns bit 15 set and removes that entry; on an empty store it returns 0x0000 and removes nothing.
- R2: Bits 11:8 of the receive word carry the line number and bits 7:0 the character, with bits above the programmed length forced to zero. The length field is line word bits 1:0: 00=5, 01=6, 10=7, 11=8 bits.
- R3: Bit 12 flags a parity error. It is set only when line word bit 4 (parity enable) is 1 and the XOR of the masked character and the received parity bit differs from line word bit 5 (1=odd, 0=even).
- R4: Bit 13 flags a framing error or break. It is set when stop level 0 is low, or when line word bit 2 (two stop bits) is 1 and stop level 1 is low.
- R5: Entries leave in arrival order, and the store holds 64 entries.
- R6: Characters that arrive on several lines in the same cycle are stored one per cycle, lowest line number first.
- R7: A character offered while the store holds 64 entries is dropped. Bit 14 is set on the next entry that is stored and then cleared.
- R8: The receive flag (status bit 7) sets when the entry count is at least the alarm level. With an alarm level of 0 it sets when the count is non-zero.
- R9: irq_o is high exactly when the receive flag and the enable (status bit 6) are both set. Writing status with bit 7 at 0 clears the flag unless its set condition still holds.
- R10: Writing status with bit 11 set empties the store and returns every register, including all line words and the alarm level, to zero.
- R11: Register map: address 0 is status (bits 3:0 select the line whose word address 2 accesses, bit 6 enable, bit 7 flag), address 1 is the receive word, address 2 is the selected line's format word, and address 3 is the alarm level. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 16 | Per-line character strobe |
| rx_data_i | input | 128 | Per-line character, line n in bits 8n+7:8n |
| rx_par_i | input | 16 | Per-line received parity bit |
| rx_stop_i | input | 32 | Per-line stop levels, line n in bits 2n+1:2n |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (pops on address 1) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| irq_o | output | 1 | Receive interrupt |

## Verification
The bench fills the store to exactly 64 entries and offers one more character. A design with an off-by-one full test would either keep the extra character or lose the 64th. The next stored entry must carry bit 14, which a design that forgot the pending overrun would leave clear. Two lines strobed in the same cycle catch a wrong arbiter order or a lost character. Reads of an empty store, both before and after traffic, catch a design that moves its read pointer anyway and later hands out stale entries. The alarm tests check the threshold edge (three entries below a level of four, then the fourth) and the zero-level case. They also check that a clear attempt while the count is still above the level leaves the flag set.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

  typedef enum logic [1:0] {
    REG_STAT  = 2'd0,
    REG_RXW   = 2'd1,
    REG_LINE  = 2'd2,
    REG_ALARM = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       odd;
    logic       par_en;
    logic       two_stop;
    logic [1:0] len;
  } line_cfg_t;

  // receive word bits 14:0; bit 15 (valid) is added on read
  typedef struct packed {
    logic       ovr;
    logic       fe;
    logic       pe;
    logic [3:0] line;
    logic [7:0] data;
  } silo_entry_t;

endpackage

// File: rtl/rx_silo_fmt.sv
module rx_silo_fmt
  import rx_silo_pkg::*;
(
  input  line_cfg_t  cfg_i,
  input  logic [7:0] data_i,
  input  logic       par_i,
  input  logic [1:0] stop_i,
  output logic [7:0] data_o,
  output logic       pe_o,
  output logic       fe_o
);
  logic [7:0] mask;

  always_comb begin
    case (cfg_i.len)
      2'b00:   mask = 8'h1f;
      2'b01:   mask = 8'h3f;
      2'b10:   mask = 8'h7f;
      default: mask = 8'hff;
    endcase
    data_o = data_i & mask;
    pe_o   = cfg_i.par_en && ((^data_o ^ par_i) != cfg_i.odd);
    fe_o   = !stop_i[0] || (cfg_i.two_stop && !stop_i[1]);
  end
endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 15,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full_o  = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr    <= '0;
      rptr    <= '0;
      count_o <= '0;
    end else if (clr_i) begin
      wptr    <= '0;
      rptr    <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count_o <= count_o + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr] <= wdata_i;
  end

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  assert_empty_pop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !clr_i) |=> (count_o == '0));
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int LINES = 16,
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(LINES),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LINES-1:0]   rx_valid_i,
  input  logic [LINES*8-1:0] rx_data_i,
  input  logic [LINES-1:0]   rx_par_i,
  input  logic [LINES*2-1:0] rx_stop_i,
  input  logic [1:0]         addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [15:0]        wdata_i,
  output logic [15:0]        rdata_o,
  output logic               irq_o
);
  line_cfg_t   cfg      [LINES];
  silo_entry_t hold_ent [LINES];
  silo_entry_t new_ent  [LINES];
  logic [LINES-1:0] hold_vld, gnt_vec;
  logic [LW-1:0]    line_sel, gnt_idx;
  logic [CW-1:0]    alarm, count;
  logic             rie, ri, ovr_pend, found;
  logic             full, empty, push, drop_full, drop_ovw, mclr, ri_cond;
  silo_entry_t      push_ent, head;

  assign mclr = wr_i && (addr_i == REG_STAT) && wdata_i[11];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [7:0] d;
    logic       pe, fe;
    rx_silo_fmt u_fmt (
      .cfg_i  (cfg[g]),
      .data_i (rx_data_i[g*8 +: 8]),
      .par_i  (rx_par_i[g]),
      .stop_i (rx_stop_i[g*2 +: 2]),
      .data_o (d),
      .pe_o   (pe),
      .fe_o   (fe)
    );
    assign new_ent[g] = '{ovr: 1'b0, fe: fe, pe: pe, line: 4'(g), data: d};
  end

  // fixed priority, lowest line first
  always_comb begin
    found   = 1'b0;
    gnt_idx = '0;
    gnt_vec = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hold_vld[i] && !found) begin
        found      = 1'b1;
        gnt_idx    = LW'(i);
        gnt_vec[i] = 1'b1;
      end
    end
  end

  assign push      = found && !full && !mclr;
  assign drop_full = found && full;
  assign drop_ovw  = |(rx_valid_i & hold_vld & ~gnt_vec);

  always_comb begin
    push_ent     = hold_ent[gnt_idx];
    push_ent.ovr = ovr_pend;
  end

  rx_silo_fifo #(.DEPTH(DEPTH), .W($bits(silo_entry_t))) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (mclr),
    .push_i  (push),
    .wdata_i (push_ent),
    .pop_i   (rd_i && (addr_i == REG_RXW)),
    .rdata_o (head),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  assign ri_cond = (alarm == '0) ? !empty : (count >= alarm);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld <= '0;
      for (int i = 0; i < LINES; i++) hold_ent[i] <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (mclr) hold_vld[i] <= 1'b0;
        else if (rx_valid_i[i]) begin
          hold_vld[i] <= 1'b1;
          hold_ent[i] <= new_ent[i];
        end else if (gnt_vec[i]) hold_vld[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_pend <= 1'b0;
      ri       <= 1'b0;
      rie      <= 1'b0;
      line_sel <= '0;
      alarm    <= '0;
      for (int i = 0; i < LINES; i++) cfg[i] <= '0;
    end else if (mclr) begin
      ovr_pend <= 1'b0;
      ri       <= 1'b0;
      rie      <= 1'b0;
      line_sel <= '0;
      alarm    <= '0;
      for (int i = 0; i < LINES; i++) cfg[i] <= '0;
    end else begin
      ovr_pend <= drop_full || drop_ovw || (ovr_pend && !push);
      if (ri_cond) ri <= 1'b1;
      else if (wr_i && addr_i == REG_STAT && !wdata_i[7]) ri <= 1'b0;
      if (wr_i) begin
        case (addr_i)
          REG_STAT: begin
            line_sel <= wdata_i[LW-1:0];
            rie      <= wdata_i[6];
          end
          REG_LINE: cfg[line_sel] <= '{odd: wdata_i[5], par_en: wdata_i[4],
                                       two_stop: wdata_i[2], len: wdata_i[1:0]};
          REG_ALARM: alarm <= wdata_i[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  assign irq_o = ri && rie;

  always_comb begin
    case (addr_i)
      REG_STAT:  rdata_o = {8'h00, ri, rie, 2'b00, 4'(line_sel)};
      REG_RXW:   rdata_o = empty ? 16'h0000 : {1'b1, head};
      REG_LINE:  rdata_o = {10'h000, cfg[line_sel].odd, cfg[line_sel].par_en, 1'b0,
                           cfg[line_sel].two_stop, cfg[line_sel].len};
      default:   rdata_o = 16'(alarm);
    endcase
  end

  assert_full_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_full && !mclr) |=> ovr_pend);

  assert_flag_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ri_cond && !mclr) |=> ri);

  assert_flag_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_STAT && !wdata_i[7] && !ri_cond) |=> !ri);

  assert_master_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr |=> (empty && !ri && !rie && !irq_o));

  assert_one_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_vec));
endmodule

// File: tb/sim_rx_silo.sv
module sim_rx_silo;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [15:0]  rx_valid = '0;
  logic [127:0] rx_data = '0;
  logic [15:0]  rx_par = '0;
  logic [31:0]  rx_stop = '1;
  logic [1:0]   addr = '0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [15:0]  wdata = '0;
  logic [15:0]  rdata;
  logic         irq;

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  logic [5:0]  cfg_m [16];
  logic        ovr_m = 1'b0;

  always #2.5 clk = ~clk;

  rx_silo u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_par_i(rx_par), .rx_stop_i(rx_stop), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    if (a == 2'd2) cfg_m[cur_sel] = d[5:0];
    if (a == 2'd0) cur_sel = d[3:0];
    @(negedge clk);
    wr = 1'b0;
  endtask

  logic [3:0] cur_sel = '0;

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  function automatic logic [15:0] model(input int ln, input logic [7:0] d,
                                        input logic p, input logic [1:0] s);
    logic [5:0] c = cfg_m[ln];
    logic [7:0] m;
    logic pe, fe;
    case (c[1:0])
      2'b00: m = d & 8'h1f;
      2'b01: m = d & 8'h3f;
      2'b10: m = d & 8'h7f;
      default: m = d;
    endcase
    pe = c[4] && ((^m ^ p) != c[5]);
    fe = !s[0] || (c[2] && !s[1]);
    return {1'b1, 1'b0, fe, pe, 4'(ln), m};
  endfunction

  // driver: strobes one or two lines and pushes the expected words
  task automatic send(input int l1, input logic [7:0] d1, input logic p1,
                      input logic [1:0] s1, input int l2 = -1,
                      input logic [7:0] d2 = 8'h00);
    logic [15:0] e;
    @(negedge clk);
    rx_valid[l1] = 1'b1; rx_data[l1*8 +: 8] = d1; rx_par[l1] = p1;
    rx_stop[l1*2 +: 2] = s1;
    if (l2 >= 0) begin
      rx_valid[l2] = 1'b1; rx_data[l2*8 +: 8] = d2; rx_par[l2] = 1'b0;
      rx_stop[l2*2 +: 2] = 2'b11;
    end
    for (int k = 0; k < 2; k++) begin
      int ln = (k == 0) ? ((l2 >= 0 && l2 < l1) ? l2 : l1)
                        : ((l2 >= 0 && l2 < l1) ? l1 : l2);
      if (ln < 0) continue;
      e = (ln == l1) ? model(l1, d1, p1, s1) : model(l2, d2, 1'b0, 2'b11);
      if (exp_q.size() >= 64) ovr_m = 1'b1;
      else begin
        e[14] = ovr_m; ovr_m = 1'b0;
        exp_q.push_back(e);
      end
    end
    @(negedge clk);
    rx_valid = '0; rx_stop = '1;
  endtask

  // monitor: pops the design's receive word and compares with the scoreboard
  task automatic pop_cmp(input string req);
    logic [15:0] e, a;
    e = exp_q.size() > 0 ? exp_q.pop_front() : 16'h0000;
    @(negedge clk);
    addr = 2'd1; rd = 1'b1;
    #1 a = rdata;
    check(a === e, req, a, e);
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 16; i++) cfg_m[i] = '0;
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(1);

    reg_rd(2'd0, v); check(v === 16'h0000, "R11 status reset", v, 16'h0000);
    check(irq === 1'b0, "R9 irq reset", {15'b0, irq}, 16'h0);
    pop_cmp("R1 empty read");

    // R2 tag and masking, R11 line word readback
    reg_wr(2'd0, 16'h0002);
    reg_wr(2'd2, 16'h0003);
    reg_rd(2'd2, v); check(v === 16'h0003, "R11 line word", v, 16'h0003);
    send(2, 8'hA5, 1'b0, 2'b11);
    wait_n(2);
    pop_cmp("R2 8-bit line 2");
    pop_cmp("R1 empty after drain");
    send(0, 8'hFF, 1'b0, 2'b11);
    wait_n(2);
    pop_cmp("R1 R2 5-bit after empty read");

    // R3 parity
    reg_wr(2'd0, 16'h0005); reg_wr(2'd2, 16'h0012);
    reg_wr(2'd0, 16'h0007); reg_wr(2'd2, 16'h0032);
    send(5, 8'h83, 1'b0, 2'b11);
    send(5, 8'h83, 1'b1, 2'b11);
    send(7, 8'h01, 1'b0, 2'b11);
    send(7, 8'h01, 1'b1, 2'b11);
    wait_n(2);
    for (int i = 0; i < 4; i++) pop_cmp("R3 parity");

    // R4 framing
    reg_wr(2'd0, 16'h0009); reg_wr(2'd2, 16'h0007);
    send(9, 8'h55, 1'b0, 2'b01);
    send(9, 8'h55, 1'b0, 2'b10);
    send(9, 8'h55, 1'b0, 2'b11);
    send(2, 8'h11, 1'b0, 2'b01);
    send(2, 8'h12, 1'b0, 2'b00);
    wait_n(2);
    for (int i = 0; i < 5; i++) pop_cmp("R4 framing");

    // R6 same-cycle arrivals
    send(9, 8'h99, 1'b0, 2'b11, 3, 8'h33);
    send(1, 8'h0A, 1'b0, 2'b11, 15, 8'hF0);
    wait_n(3);
    for (int i = 0; i < 4; i++) pop_cmp("R6 priority order");

    // R5 depth and order, R7 overrun
    for (int i = 0; i < 65; i++) send(2, 8'(i), 1'b0, 2'b11);
    wait_n(2);
    for (int i = 0; i < 64; i++) pop_cmp("R5 order full depth");
    pop_cmp("R7 dropped char absent");
    send(2, 8'h7E, 1'b0, 2'b11);
    wait_n(2);
    pop_cmp("R7 overrun bit on next entry");

    // R8 R9 alarm and interrupt
    reg_wr(2'd3, 16'h0004);
    reg_wr(2'd0, 16'h0040);
    for (int i = 0; i < 3; i++) send(2, 8'h40 + 8'(i), 1'b0, 2'b11);
    wait_n(3);
    check(irq === 1'b0, "R8 below alarm", {15'b0, irq}, 16'h0);
    send(2, 8'h43, 1'b0, 2'b11);
    wait_n(3);
    check(irq === 1'b1, "R8 alarm reached", {15'b0, irq}, 16'h1);
    reg_rd(2'd0, v); check(v === 16'h00C0, "R9 status flag", v, 16'h00C0);
    reg_wr(2'd0, 16'h0040);
    wait_n(1);
    check(irq === 1'b1, "R9 clear ignored above level", {15'b0, irq}, 16'h1);
    for (int i = 0; i < 4; i++) pop_cmp("R5 alarm data");
    reg_wr(2'd0, 16'h0040);
    wait_n(1);
    check(irq === 1'b0, "R9 flag cleared", {15'b0, irq}, 16'h0);
    reg_wr(2'd3, 16'h0000);
    send(4, 8'h04, 1'b0, 2'b11);
    wait_n(3);
    check(irq === 1'b1, "R8 zero level non-empty", {15'b0, irq}, 16'h1);
    pop_cmp("R2 zero level data");
    reg_wr(2'd0, 16'h0000);
    reg_rd(2'd0, v); check(v === 16'h0000, "R9 flag and enable clear", v, 16'h0000);

    // R10 master clear
    reg_wr(2'd3, 16'h0005);
    send(2, 8'h21, 1'b0, 2'b11);
    send(2, 8'h22, 1'b0, 2'b11);
    wait_n(2);
    reg_wr(2'd0, 16'h0800);
    exp_q.delete(); ovr_m = 1'b0;
    for (int i = 0; i < 16; i++) cfg_m[i] = '0;
    pop_cmp("R10 store emptied");
    reg_rd(2'd3, v); check(v === 16'h0000, "R10 alarm cleared", v, 16'h0000);
    reg_wr(2'd0, 16'h0002);
    reg_rd(2'd2, v); check(v === 16'h0000, "R10 line word cleared", v, 16'h0000);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule